// File: doc/BRIEF.md
# Single-Precision Class Test Unit

This unit classifies one 32-bit IEEE-754 single-precision operand into one of ten disjoint classes. It then reports whether that class is among those picked by a 10-bit select mask. A 2-bit modifier can clear or flip the operand's sign before the operand is classified. Only the sign bit changes, so every class keeps its magnitude category and only the negative or positive side can move.

Two outputs come from the unit. The first is a one-bit match. The second is the one-hot class vector, which is brought out for debug. A parameter chooses between a purely combinational path and a single output register with an active-low asynchronous reset. A vector unit can use this unit wherever a class-compare instruction has to be evaluated.

Top module: `fpcls_unit`

## Requirements
- R1: Class vector and mask share this bit order: bit 0 signaling NaN, 1 quiet NaN, 2 negative infinity, 3 negative normal, 4 negative subnormal, 5 negative zero, 6 positive zero, 7 positive subnormal, 8 positive normal, 9 positive infinity.
- R2: `result_o` is 1 exactly when some bit set in `mask_i` is also set in the class vector of the modified operand.
- R3: With `mask_i` all zeros, `result_o` is 0 for every operand and modifier.
- R4: `class_o` has exactly one bit set for every operand once out of reset.
- R5: Exponent all ones with a nonzero mantissa is a NaN. It is quiet when mantissa bit 22 is 1 and signaling when that bit is 0, and its sign has no effect on the class.
- R6: Exponent 0 with mantissa 0 is zero, and exponent 0 with a nonzero mantissa is subnormal. Exponent all ones with mantissa 0 is infinity. Every other encoding is normal. The sign (bit 31) picks the negative or the positive class.
- R7: `mod_i` bit 0 alone inverts the sign bit before classification.
- R8: `mod_i` bit 1 alone clears the sign bit before classification.
- R9: With both `mod_i` bits set, the sign bit is forced to 1. Bits 30:0 are never changed by any modifier.
- R10: With `OUT_REG`=1, the outputs appear one clock after the inputs, and reset drives `result_o` and `class_o` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock (used when OUT_REG=1) |
| rst_ni | input | 1 | Active-low asynchronous reset |
| operand_i | input | 32 | Single-precision operand |
| mask_i | input | 10 | Class select mask |
| mod_i | input | 2 | Bit 0 negate, bit 1 absolute value |
| result_o | output | 1 | Match of any selected class |
| class_o | output | 10 | One-hot class of the modified operand |

## Verification
Every fault in the decode or the modifier shows up on `class_o` one clock after the operand is applied. It appears either as a class bit at the wrong position or as a vector that is not one-hot. The mask path is then checked separately through `result_o` under empty, full and single-bit masks. The operands cover the class boundaries: the smallest and largest subnormal, the smallest and largest normal, both zeros, both infinities and both NaN kinds. Each of these operands is tried with all four modifier codes, so a fault in the sign logic shows up as a class moving to the wrong side.

// File: rtl/fpcls_pkg.sv
package fpcls_pkg;
  localparam int unsigned WORD_W = 32;
  localparam int unsigned EXP_W  = 8;
  localparam int unsigned MAN_W  = 23;
  localparam int unsigned NCLS   = 10;
  localparam int unsigned SIGN_B = WORD_W - 1;
  localparam int unsigned QBIT   = MAN_W - 1;

  typedef enum logic [3:0] {
    CLS_SNAN = 4'd0, CLS_QNAN = 4'd1, CLS_NINF = 4'd2, CLS_NNORM = 4'd3,
    CLS_NSUB = 4'd4, CLS_NZERO = 4'd5, CLS_PZERO = 4'd6, CLS_PSUB = 4'd7,
    CLS_PNORM = 4'd8, CLS_PINF = 4'd9
  } cls_idx_e;

  typedef struct packed {
    logic             sign;
    logic [EXP_W-1:0] expo;
    logic [MAN_W-1:0] man;
  } fp32_t;
endpackage

// File: rtl/fpcls_srcmod.sv
module fpcls_srcmod
  import fpcls_pkg::*;
(
  input  logic [WORD_W-1:0] op_i,
  input  logic [1:0]        mod_i,
  output logic [WORD_W-1:0] op_o
);
  logic sign_abs;
  // abs first, then negate
  assign sign_abs = mod_i[1] ? 1'b0 : op_i[SIGN_B];
  assign op_o     = {sign_abs ^ mod_i[0], op_i[SIGN_B-1:0]};
endmodule

// File: rtl/fpcls_decode.sv
module fpcls_decode
  import fpcls_pkg::*;
(
  input  logic [WORD_W-1:0] op_i,
  output logic [NCLS-1:0]   cls_o
);
  fp32_t f;
  logic exp_max, exp_min, man_nz;

  assign f       = fp32_t'(op_i);
  assign exp_max = &f.expo;
  assign exp_min = ~|f.expo;
  assign man_nz  = |f.man;

  always_comb begin
    cls_o = '0;
    if (exp_max && man_nz) begin
      if (f.man[QBIT]) cls_o[CLS_QNAN] = 1'b1;
      else             cls_o[CLS_SNAN] = 1'b1;
    end else if (exp_max) begin
      cls_o[f.sign ? CLS_NINF : CLS_PINF] = 1'b1;
    end else if (exp_min && man_nz) begin
      cls_o[f.sign ? CLS_NSUB : CLS_PSUB] = 1'b1;
    end else if (exp_min) begin
      cls_o[f.sign ? CLS_NZERO : CLS_PZERO] = 1'b1;
    end else begin
      cls_o[f.sign ? CLS_NNORM : CLS_PNORM] = 1'b1;
    end
  end
endmodule

// File: rtl/fpcls_unit.sv
module fpcls_unit
  import fpcls_pkg::*;
#(
  parameter bit OUT_REG = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [WORD_W-1:0] operand_i,
  input  logic [NCLS-1:0]   mask_i,
  input  logic [1:0]        mod_i,
  output logic              result_o,
  output logic [NCLS-1:0]   class_o
);
  logic [WORD_W-1:0] op_m;
  logic [NCLS-1:0]   cls_d;
  logic              res_d;

  fpcls_srcmod u_mod (.op_i(operand_i), .mod_i(mod_i), .op_o(op_m));
  fpcls_decode u_dec (.op_i(op_m), .cls_o(cls_d));

  assign res_d = |(mask_i & cls_d);

  generate
    if (OUT_REG) begin : g_reg
      logic              res_q;
      logic [NCLS-1:0]   cls_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          res_q <= 1'b0;
          cls_q <= '0;
        end else begin
          res_q <= res_d;
          cls_q <= cls_d;
        end
      end
      assign result_o = res_q;
      assign class_o  = cls_q;

      AST_REG_LATENCY: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $past(rst_ni) |-> (class_o == $past(cls_d))) else $error("latency"); // R10
    end else begin : g_comb
      assign result_o = res_d;
      assign class_o  = cls_d;
    end
  endgenerate

  AST_CLASS_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(cls_d) == 1) else $error("class not one-hot"); // R4
  AST_EMPTY_MASK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mask_i == '0) |-> !res_d) else $error("empty mask hit"); // R3
  AST_MOD_BOTH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mod_i == 2'b11) |-> op_m[SIGN_B]) else $error("sign not forced"); // R9
  AST_MOD_ABS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mod_i == 2'b10) |-> !op_m[SIGN_B]) else $error("abs failed"); // R8
  AST_MOD_NEG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mod_i == 2'b01) |-> (op_m[SIGN_B] != operand_i[SIGN_B])) else $error("neg failed"); // R7
  AST_MAG_KEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_m[SIGN_B-1:0] == operand_i[SIGN_B-1:0]) else $error("magnitude changed"); // R9
  AST_NAN_CLASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((&operand_i[30:23]) && (|operand_i[22:0])) |-> (cls_d[1:0] != 2'b00))
    else $error("nan misclassed"); // R5
endmodule

// File: tb/tb_fpcls_unit.sv
`timescale 1ns/1ps
module tb_fpcls_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] op = '0;
  logic [9:0]  mask = '0;
  logic [1:0]  mod = '0;
  logic        result;
  logic [9:0]  cls;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  logic [10:0] exp_q[$];   // {result, class}
  string       tag_q[$];

  always #10 clk = ~clk;   // 50 MHz

  fpcls_unit #(.OUT_REG(1'b1)) dut (
    .clk_i(clk), .rst_ni(rst_n), .operand_i(op), .mask_i(mask), .mod_i(mod),
    .result_o(result), .class_o(cls)
  );

  function automatic logic [9:0] ref_cls(logic [31:0] x, logic [1:0] m);
    logic s;
    logic [7:0] e;
    logic [22:0] f;
    s = x[31]; e = x[30:23]; f = x[22:0];
    if (m[1]) s = 1'b0;
    if (m[0]) s = ~s;
    ref_cls = '0;
    if (e == 8'hFF && f != 0)  ref_cls[f[22] ? 1 : 0] = 1'b1;
    else if (e == 8'hFF)       ref_cls[s ? 2 : 9] = 1'b1;
    else if (e == 0 && f != 0) ref_cls[s ? 4 : 7] = 1'b1;
    else if (e == 0)           ref_cls[s ? 5 : 6] = 1'b1;
    else                       ref_cls[s ? 3 : 8] = 1'b1;
  endfunction

  task automatic drive(logic [31:0] x, logic [9:0] mk, logic [1:0] m, string tag);
    logic [9:0] c;
    @(negedge clk);
    op = x; mask = mk; mod = m;
    c = ref_cls(x, m);
    exp_q.push_back({|(c & mk), c});
    tag_q.push_back(tag);
  endtask

  initial begin : monitor
    logic [10:0] e;
    string t;
    forever begin
      @(posedge clk);
      #5;
      if (exp_q.size() > 0) begin
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        n_chk++;
        if ({result, cls} !== e) begin
          n_bad++;
          $display("FAIL %s op=%h mask=%h mod=%0d act=%b/%b exp=%b/%b",
                   t, op, mask, mod, result, cls, e[10], e[9:0]);
        end
      end
    end
  end

  logic [31:0] pts [16];
  initial begin
    pts[0]  = 32'h0000_0000; pts[1]  = 32'h8000_0000;   // zeros R6
    pts[2]  = 32'h0000_0001; pts[3]  = 32'h007F_FFFF;   // min/max subnormal
    pts[4]  = 32'h0080_0000; pts[5]  = 32'h7F7F_FFFF;   // min/max normal
    pts[6]  = 32'h7F80_0000; pts[7]  = 32'hFF80_0000;   // infinities
    pts[8]  = 32'h7FC0_0000; pts[9]  = 32'hFFC0_0001;   // quiet NaN R5
    pts[10] = 32'h7F80_0001; pts[11] = 32'hFFBF_FFFF;   // signaling NaN R5
    pts[12] = 32'h3F80_0000; pts[13] = 32'hBF80_0000;
    pts[14] = 32'h807F_FFFF; pts[15] = 32'h8080_0000;
  end

  initial begin : driver
    logic [31:0] lfsr;
    lfsr = 32'hACE1_1234;
    repeat (3) @(negedge clk);
    // R10: reset state
    n_chk++;
    if (result !== 1'b0 || cls !== 10'h0) begin
      n_bad++;
      $display("FAIL R10 reset act=%b/%b exp=0/0000000000", result, cls);
    end
    rst_n = 1'b1;
    for (int i = 0; i < 16; i++)
      for (int m = 0; m < 4; m++) begin
        drive(pts[i], 10'h000, 2'(m), "R3");
        drive(pts[i], 10'h3FF, 2'(m), "R2");
        for (int b = 0; b < 10; b++)
          drive(pts[i], 10'(1 << b), 2'(m),
                m == 0 ? "R1_R6" : m == 1 ? "R7" : m == 2 ? "R8" : "R9");
      end
    for (int k = 0; k < 3000; k++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      drive(k[0] ? lfsr : {lfsr[31], (k[2] ? 8'hFF : 8'h00), lfsr[22:0]},
            lfsr[9:0] ^ 10'(k), lfsr[13:12], "R2_R4");
    end
    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
  end

  initial begin : finisher
    fork
      wait (done && exp_q.size() == 0);
      begin
        #(20ns * 150000);
        n_chk++; n_bad++;
        $display("FAIL watchdog act=hung exp=done");
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule